// File: doc/BRIEF.md
# Card Clock Source Selector and Divider

This block produces the clock sent to a smart card and a second, companion clock output. The card clock can come from one of three sources: an external strobe clock, an RC oscillator or a crystal oscillator. A latched clock-select bit chooses between the strobe and the internal oscillators. Two divide-select bits choose the rate. The card clock can be the source divided by four, the source divided by two, a fixed rate taken from the RC oscillator, or held low.

The three sources enter as digital levels. They are sampled by a fast reference clock and their rising edges are detected. All dividing and switching is then done in that single reference domain. Every change of source or mode follows the same order. Any high phase in progress is allowed to end, the output is held low for at least one full period of the new source, and only then does dividing start again. This keeps the card clock free of short pulses.

The companion output shows the internal oscillator while that oscillator is in use. In sleep mode it runs at a much lower rate, close to 16 kHz, from a divider whose ratio is computed when the design is elaborated. An activation-busy input freezes the clock-select bit, so that the source cannot change while a card is being activated.

Top module: `card_clk_gen`

## Requirements
- R1: While the reset input is low, both the card clock and the companion clock are low.
- R2: When the latched clock-select bit is high, the card clock is derived from the strobe input. When that bit is low, the card clock is derived from the crystal oscillator, except in the fixed-rate mode.
- R3: With div_sel_i = 2'b00, the card clock period is 4 periods of the selected source.
- R4: With div_sel_i = 2'b01, the card clock period is 2 periods of the selected source.
- R5: With div_sel_i = 2'b10, the card clock period is 2*FIX_HALF periods of the RC oscillator (4 by default), whatever the value of the clock-select bit.
- R6: With div_sel_i = 2'b11, the card clock falls low within one period of the source in use plus 4 reference cycles, and it stays low.
- R7: When the internal oscillator is selected and sleep is low, the companion clock has the period of that oscillator. The oscillator is the RC oscillator when div_sel_i = 2'b10 and the crystal otherwise. When the strobe is selected, the companion clock is held low.
- R8: With sleep high and the internal oscillator selected, the companion clock period is 2*SLEEP_HALF periods of the internal oscillator. SLEEP_HALF rounds OSC_HZ/SLEEP_HZ/2 to the nearest whole number, which gives 250 periods by default.
- R9: The clock-select input is latched only while act_busy_i is low. Changes made while act_busy_i is high have no effect on the card clock.
- R10: No high phase and no low phase of the card clock is shorter than the shortest source period, including the phases around a change of source or mode.
- R11: After leaving the hold-low mode, the card clock stays low for at least one period of the new source. It then rises cleanly and runs at the rate set by R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that samples all sources |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strobe_i | input | 1 | External strobe clock level |
| rc_osc_i | input | 1 | RC oscillator clock level |
| xtal_osc_i | input | 1 | Crystal oscillator clock level |
| clk_sel_i | input | 1 | 1 selects the strobe, 0 selects the internal oscillator |
| div_sel_i | input | 2 | Rate select: 00 /4, 01 /2, 10 fixed from RC, 11 held low |
| act_busy_i | input | 1 | When high, clk_sel_i is not latched |
| sleep_i | input | 1 | Slows the companion clock |
| card_clk_o | output | 1 | Clock driven to the card |
| aux_clk_o | output | 1 | Companion clock output |

## Verification
A source edge reaches the dividers two synchronizer stages and one edge-detect register after it occurs. The clock-select bit is latched one reference cycle after it is driven, and entry into the hold-low mode must show within one source period plus four reference cycles. The bench never samples at a fixed latency. It waits for two rising edges of the output after each change, then measures the time from one rising edge to the next in reference cycles and compares it with a multiple of the source period. These measurements do not depend on the constant synchronizer delay. The hold-low check is taken 20 reference cycles after the change, and a monitor measures every card clock phase throughout the run to check R10.

// File: rtl/cc_pkg.sv
package cc_pkg;

  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    MD_DIV4  = 2'b00,
    MD_DIV2  = 2'b01,
    MD_FIXED = 2'b10,
    MD_STOP  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SRC_STROBE = 2'd0,
    SRC_RC     = 2'd1,
    SRC_XTAL   = 2'd2
  } src_e;

  typedef struct packed {
    src_e  src;
    mode_e mode;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_QUIET = 2'd2
  } sw_state_e;

endpackage

// File: rtl/cc_edge_sync.sv
module cc_edge_sync #(
  parameter int N_SRC       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] lvl_o,
  output logic [N_SRC-1:0] rise_o
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic                   prev_q, prev_d;

    always_comb begin
      sync_d = {sync_q[SYNC_STAGES-2:0], src_i[g]};
      prev_d = sync_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= sync_d;
        prev_q <= prev_d;
      end
    end

    assign lvl_o[g]  = sync_q[LAST];
    assign rise_o[g] = sync_q[LAST] & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]); // R2
  end

endmodule

// File: rtl/cc_cfg_lock.sv
module cc_cfg_lock
  import cc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_sel_i,
  input  logic       act_busy_i,
  input  logic [1:0] div_sel_i,
  output cfg_t       cfg_o,
  output logic       strobe_sel_o,
  output src_e       int_src_o
);

  logic  sel_q, sel_d;
  logic  sel_en;
  mode_e mode;

  assign sel_en = ~act_busy_i;

  always_comb begin
    sel_d = sel_q;
    if (sel_en) sel_d = clk_sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  always_comb begin
    mode       = mode_e'(div_sel_i);
    cfg_o.mode = mode;
    if (mode == MD_FIXED)  cfg_o.src = SRC_RC;
    else if (sel_q)        cfg_o.src = SRC_STROBE;
    else                   cfg_o.src = SRC_XTAL;
    int_src_o = (mode == MD_FIXED) ? SRC_RC : SRC_XTAL;
  end

  assign strobe_sel_o = sel_q;

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    act_busy_i |=> $stable(strobe_sel_o)); // R9

endmodule

// File: rtl/cc_card_div.sv
module cc_card_div
  import cc_pkg::*;
#(
  parameter int FIX_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cfg_t               cfg_i,
  input  logic [NUM_SRC-1:0] rise_i,
  output logic               card_clk_o
);

  localparam int HALF_MAX = (FIX_HALF > 2) ? FIX_HALF : 2;
  localparam int CNT_W    = $clog2(HALF_MAX + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  sw_state_e        st_q, st_d;
  cfg_t             cfg_q, cfg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clk_q, clk_d;

  logic             old_rise;
  logic             new_rise;
  logic             cfg_chg;
  logic [CNT_W-1:0] half;

  assign old_rise = rise_i[cfg_q.src];
  assign new_rise = rise_i[cfg_i.src];
  assign cfg_chg  = (cfg_i != cfg_q);

  always_comb begin
    case (cfg_q.mode)
      MD_DIV2:  half = CNT_W'(1);
      MD_DIV4:  half = CNT_W'(2);
      MD_FIXED: half = CNT_W'(FIX_HALF);
      default:  half = CNT_W'(1);
    endcase
  end

  always_comb begin
    st_d  = st_q;
    cfg_d = cfg_q;
    cnt_d = cnt_q;
    clk_d = clk_q;
    case (st_q)
      ST_RUN: begin
        if (cfg_chg) begin
          if (clk_q) begin
            st_d = ST_DRAIN;
          end else begin
            cfg_d = cfg_i;
            cnt_d = '0;
            st_d  = ST_QUIET;
          end
        end else if (old_rise && (cfg_q.mode != MD_STOP)) begin
          if (cnt_q == half - ONE) begin
            cnt_d = '0;
            clk_d = ~clk_q;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      ST_DRAIN: begin
        if (old_rise) begin
          clk_d = 1'b0;
          cfg_d = cfg_i;
          cnt_d = '0;
          st_d  = ST_QUIET;
        end
      end
      ST_QUIET: begin
        if (cfg_chg) begin
          cfg_d = cfg_i;
          cnt_d = '0;
        end else if (new_rise) begin
          if (cnt_q == ONE) begin
            cnt_d = '0;
            st_d  = ST_RUN;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      default: begin
        st_d  = ST_QUIET;
        clk_d = 1'b0;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_QUIET;
      cfg_q <= '{src: SRC_XTAL, mode: MD_DIV4};
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cfg_q <= cfg_d;
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign card_clk_o = clk_q;

  AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_QUIET) |-> !card_clk_o); // R10

  AST_DRAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && old_rise) |=> (!card_clk_o && st_q == ST_QUIET)); // R10

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cfg_q.mode == MD_STOP) |-> !card_clk_o); // R6

  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !old_rise && !cfg_chg) |=> $stable(card_clk_o)); // R3

endmodule

// File: rtl/cc_aux_out.sv
module cc_aux_out
  import cc_pkg::*;
#(
  parameter int SLEEP_HALF = 125
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe_sel_i,
  input  src_e               int_src_i,
  input  logic               sleep_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  input  logic [NUM_SRC-1:0] rise_i,
  output logic               aux_o
);

  localparam int SCNT_W = $clog2(SLEEP_HALF + 1);
  localparam logic [SCNT_W-1:0] S_ONE  = SCNT_W'(1);
  localparam logic [SCNT_W-1:0] S_LAST = SCNT_W'(SLEEP_HALF - 1);

  logic [SCNT_W-1:0] scnt_q, scnt_d;
  logic              slow_q, slow_d;
  logic              aux_q, aux_d;
  logic              tick;

  assign tick = rise_i[int_src_i];

  always_comb begin
    scnt_d = scnt_q;
    slow_d = slow_q;
    if (!sleep_i) begin
      scnt_d = '0;
      slow_d = 1'b0;
    end else if (tick) begin
      if (scnt_q == S_LAST) begin
        scnt_d = '0;
        slow_d = ~slow_q;
      end else begin
        scnt_d = scnt_q + S_ONE;
      end
    end
  end

  always_comb begin
    if (strobe_sel_i) aux_d = 1'b0;
    else if (sleep_i) aux_d = slow_q;
    else              aux_d = lvl_i[int_src_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= '0;
      slow_q <= 1'b0;
      aux_q  <= 1'b0;
    end else begin
      scnt_q <= scnt_d;
      slow_q <= slow_d;
      aux_q  <= aux_d;
    end
  end

  assign aux_o = aux_q;

  AST_AUX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_sel_i |=> !aux_o); // R7

  AST_SLOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |=> !slow_q); // R8

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import cc_pkg::*;
#(
  parameter int OSC_HZ      = 4_000_000,
  parameter int SLEEP_HZ    = 16_000,
  parameter int FIX_HALF    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_i,
  input  logic       rc_osc_i,
  input  logic       xtal_osc_i,
  input  logic       clk_sel_i,
  input  logic [1:0] div_sel_i,
  input  logic       act_busy_i,
  input  logic       sleep_i,
  output logic       card_clk_o,
  output logic       aux_clk_o
);

  localparam int SLEEP_HALF_RAW = (OSC_HZ + SLEEP_HZ) / (2 * SLEEP_HZ);
  localparam int SLEEP_HALF     = (SLEEP_HALF_RAW < 1) ? 1 : SLEEP_HALF_RAW;

  logic               rst_meta_q, rst_sync_q;
  logic [NUM_SRC-1:0] src_vec;
  logic [NUM_SRC-1:0] lvl;
  logic [NUM_SRC-1:0] rise;
  cfg_t               cfg;
  logic               strobe_sel;
  src_e               int_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    src_vec             = '0;
    src_vec[SRC_STROBE] = strobe_i;
    src_vec[SRC_RC]     = rc_osc_i;
    src_vec[SRC_XTAL]   = xtal_osc_i;
  end

  cc_edge_sync #(
    .N_SRC      (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .src_i (src_vec),
    .lvl_o (lvl),
    .rise_o(rise)
  );

  cc_cfg_lock u_cfg (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .clk_sel_i   (clk_sel_i),
    .act_busy_i  (act_busy_i),
    .div_sel_i   (div_sel_i),
    .cfg_o       (cfg),
    .strobe_sel_o(strobe_sel),
    .int_src_o   (int_src)
  );

  cc_card_div #(
    .FIX_HALF(FIX_HALF)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cfg_i     (cfg),
    .rise_i    (rise),
    .card_clk_o(card_clk_o)
  );

  cc_aux_out #(
    .SLEEP_HALF(SLEEP_HALF)
  ) u_aux (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .strobe_sel_i(strobe_sel),
    .int_src_i   (int_src),
    .sleep_i     (sleep_i),
    .lvl_i       (lvl),
    .rise_i      (rise),
    .aux_o       (aux_clk_o)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_sync_q |=> (!card_clk_o && !aux_clk_o)); // R1

endmodule

// File: tb/card_clk_gen_tb.sv
`timescale 1ns/1ps
module card_clk_gen_tb;

  localparam int RC_P   = 10;
  localparam int XT_P   = 12;
  localparam int STB_P  = 14;
  localparam int FIXH   = 2;
  localparam int SLEEPR = 250;
  localparam int MINPH  = 10;
  localparam int TMO    = 9000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobe = 1'b0, rc = 1'b0, xtal = 1'b0;
  logic       clk_sel, act_busy, sleep;
  logic [1:0] div_sel;
  logic       card_clk, aux_clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit mon_en = 0;
  int glitches = 0;
  int run_len = 1000;
  logic last_lvl = 1'b0;

  card_clk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .rc_osc_i(rc),
    .xtal_osc_i(xtal), .clk_sel_i(clk_sel), .div_sel_i(div_sel),
    .act_busy_i(act_busy), .sleep_i(sleep),
    .card_clk_o(card_clk), .aux_clk_o(aux_clk)
  );

  always #2.5 clk = ~clk;
  initial forever #25 rc = ~rc;
  initial forever #30 xtal = ~xtal;
  initial forever #35 strobe = ~strobe;

  always @(negedge clk) begin
    if (mon_en) begin
      if (card_clk != last_lvl) begin
        if (run_len < MINPH) glitches++;
        run_len = 1;
      end else begin
        run_len++;
      end
      last_lvl = card_clk;
    end
  end

  function automatic int exp_card(input bit sel, input int dv);
    int sp;
    if (dv == 3) return 0;
    sp = (dv == 2) ? RC_P : (sel ? STB_P : XT_P);
    if (dv == 0) return 4 * sp;
    if (dv == 1) return 2 * sp;
    return 2 * FIXH * sp;
  endfunction

  function automatic int exp_aux(input bit sel, input int dv, input bit slp);
    int ip;
    if (sel) return 0;
    ip = (dv == 2) ? RC_P : XT_P;
    return slp ? SLEEPR * ip : ip;
  endfunction

  function automatic logic pick(input bit use_aux);
    return use_aux ? aux_clk : card_clk;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas(input bit use_aux, output int per);
    int got, t0;
    logic prev, cur;
    got = 0; t0 = 0; per = 0;
    @(negedge clk);
    prev = pick(use_aux);
    for (int i = 0; i < TMO && got < 2; i++) begin
      @(negedge clk);
      cur = pick(use_aux);
      if (cur && !prev) begin
        if (got == 0) t0 = i;
        else per = i - t0;
        got++;
      end
      prev = cur;
    end
  endtask

  task automatic high_count(input bit use_aux, input int n, output int hc);
    hc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pick(use_aux)) hc++;
    end
  endtask

  task automatic drive(input bit s, input int dv, input bit b, input bit slp);
    @(negedge clk);
    clk_sel  = s;
    div_sel  = dv[1:0];
    act_busy = b;
    sleep    = slp;
    repeat (8) @(negedge clk);
  endtask

  function automatic string card_tag(input int dv);
    if (dv == 0) return "R3";
    if (dv == 1) return "R4";
    return "R5";
  endfunction

  initial begin
    int per, hc, dummy;
    bit sel_m, s_r, b_r, slp_r;
    int d_r;
    dummy = int'($urandom(32'h0005_eed1));
    rst_n = 1'b0; clk_sel = 1'b0; div_sel = 2'b00; act_busy = 1'b0; sleep = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1 card_clk in reset", int'(card_clk), 0);
    chk("R1 aux_clk in reset", int'(aux_clk), 0);
    @(negedge clk);
    rst_n = 1'b1;
    sel_m = 1'b0;

    // crystal, divide by 4
    drive(0, 0, 0, 0);
    meas(0, per); meas(0, per);
    chk("R3 xtal div4", per, exp_card(0, 0));
    mon_en = 1;
    meas(1, per);
    chk("R7 aux follows crystal", per, exp_aux(0, 0, 0));

    // crystal, divide by 2
    drive(0, 1, 0, 0);
    meas(0, per); meas(0, per);
    chk("R4 xtal div2", per, exp_card(0, 1));

    // strobe, divide by 2 and 4
    drive(1, 1, 0, 0); sel_m = 1;
    meas(0, per); meas(0, per);
    chk("R2 strobe div2", per, exp_card(1, 1));
    high_count(1, 200, hc);
    chk("R7 aux low with strobe", hc, 0);
    drive(1, 0, 0, 0);
    meas(0, per); meas(0, per);
    chk("R2 strobe div4", per, exp_card(1, 0));

    // fixed rate ignores clock-select
    drive(1, 2, 0, 0);
    meas(0, per); meas(0, per);
    chk("R5 fixed with strobe selected", per, exp_card(1, 2));
    drive(0, 2, 0, 0); sel_m = 0;
    meas(0, per); meas(0, per);
    chk("R5 fixed with internal selected", per, exp_card(0, 2));
    meas(1, per);
    chk("R7 aux follows rc", per, exp_aux(0, 2, 0));

    // stop mode from running crystal div2
    drive(0, 1, 0, 0);
    meas(0, per);
    @(negedge clk);
    div_sel = 2'b11;
    repeat (20) @(negedge clk);
    chk("R6 low after stop", int'(card_clk), 0);
    high_count(0, 300, hc);
    chk("R6 stays low", hc, 0);

    // leave stop
    div_sel = 2'b01;
    repeat (8) @(negedge clk);
    meas(0, per);
    chk("R11 resumes after stop", per, exp_card(0, 1));

    // activation lock
    drive(1, 1, 1, 0);
    meas(0, per); meas(0, per);
    chk("R9 select ignored while busy", per, exp_card(sel_m, 1));
    drive(1, 1, 0, 0); sel_m = 1;
    meas(0, per); meas(0, per);
    chk("R9 select taken when idle", per, exp_card(1, 1));

    // sleep
    drive(0, 0, 0, 1); sel_m = 0;
    meas(1, per); meas(1, per);
    chk("R8 sleep companion rate", per, exp_aux(0, 0, 1));
    drive(0, 0, 0, 0);

    // random mix
    for (int it = 0; it < 10; it++) begin
      s_r   = 1'($urandom % 2);
      d_r   = int'($urandom % 3);
      b_r   = (($urandom % 4) == 0);
      slp_r = (($urandom % 3) == 0);
      drive(s_r, d_r, b_r, slp_r);
      if (!b_r) sel_m = s_r;
      meas(0, per); meas(0, per);
      chk({card_tag(d_r), " random card period"}, per, exp_card(sel_m, d_r));
      if (exp_aux(sel_m, d_r, slp_r) == 0) begin
        high_count(1, 100, hc);
        chk("R7 random aux low", hc, 0);
      end else begin
        meas(1, per);
        if (slp_r) meas(1, per);
        chk(slp_r ? "R8 random sleep aux" : "R7 random aux", per, exp_aux(sel_m, d_r, slp_r));
      end
      @(negedge clk);
      act_busy = 1'b0;
      sel_m = s_r;
      repeat (4) @(negedge clk);
    end

    mon_en = 0;
    chk("R10 no short card clock phase", glitches, 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule